// File: doc/BRIEF.md
# SPI Master Word Serializer with Command/Data Lead Bit

This block shifts one word out of an SPI master on a single channel. The host presents a word and a frame configuration, then pulses a write strobe. The block then drives the serial clock and MOSI until the frame is done. It collects the bits returned on MISO into a receive word and raises a one-cycle valid pulse when the frame ends.

An optional lead bit can be shifted out ahead of the word. This bit tells the slave how to treat the word that follows: 0 means command and 1 means data. The host may change the lead bit's value between words without stopping anything. The block captures that value, together with the word and every other setting, on the write strobe. Changes made to the inputs later do not affect a frame that is already running. The lead bit is never stored in the receive word.

The bit rate is set by the `HALF_CYC` parameter, which is the length of each serial-clock half period in system clock cycles. Words are sent MSB first. Clock polarity and phase are chosen per frame.

Top module: `spi_sb_framer`

## Requirements
- R1: After reset, `busy` and `rx_valid` are 0, `mosi` is 0 and `sclk` equals the `cpol` input.
- R2: A frame carries `word_len`+1 bits (`word_len` holds the bit count minus one). When `lead_en` is 1 at the write, the frame carries one more bit.
- R3: When `lead_en` is 1, the first bit of the frame is the value of `lead_val` at the write strobe. A value of 0 marks a command and a value of 1 marks data.
- R4: The word bits are `tx_word[word_len]` down to `tx_word[0]`, MSB first. They follow the lead bit, if there is one.
- R5: While idle, `sclk` equals `cpol`. With `cpha`=0 the receiver samples MOSI on the leading clock edge, which is the edge that leaves the idle level. With `cpha`=1 it samples on the trailing edge. `mosi` is stable at each sampling edge.
- R6: Changes to `lead_val`, `lead_en`, `word_len`, `tx_word` or `cpha` after the write strobe do not change the frame in progress.
- R7: A `wr_stb` pulse while `busy` is 1 is ignored: no frame is queued and none is restarted.
- R8: At the end of the frame, `rx_valid` pulses for one cycle. `rx_word` then holds the word-length MISO samples taken after the lead bit, right-aligned with MSB first and zeros above. The lead-bit sample is dropped.
- R9: `busy` rises in the cycle after an accepted write strobe and falls after the last bit's second half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Start a frame with the present word and settings |
| tx_word | input | MAX_LEN | Word to send, right-aligned |
| word_len | input | LEN_W | Word bit count minus one |
| lead_en | input | 1 | Insert the command/data lead bit |
| lead_val | input | 1 | Lead bit value: 0 = command, 1 = data |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| busy | output | 1 | Frame in progress |
| rx_word | output | MAX_LEN | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification
The assertions assume three things about the inputs:

- `HALF_CYC` is at least 1 and `word_len` is below `MAX_LEN`.
- `cpol` is not changed while a frame is running.
- `rst_n` is released synchronously.

The stimulus keeps to these rules. It sets `cpol` only while the block is idle and drives `word_len` only from 0 up to the largest legal value. It moves the other configuration inputs during a frame on purpose, to exercise frame latching. MISO is tied back to MOSI, optionally inverted, so every captured receive word has a known value.

// File: rtl/spi_sb_pkg.sv
package spi_sb_pkg;
   typedef enum logic {
      HALF_LEAD  = 1'b0,
      HALF_TRAIL = 1'b1
   } half_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/sb_tick_gen.sv
module sb_tick_gen
   import spi_sb_pkg::*;
#(
   parameter int unsigned HALF_CYC = 2
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   output logic  mid_stb,
   output logic  end_stb,
   output half_e half
);
   localparam int unsigned CNT_W = cnt_width(HALF_CYC);

   logic last_cyc;

   generate
      if (HALF_CYC == 0) begin : g_bad
         $error("HALF_CYC must be at least 1");
      end else if (HALF_CYC == 1) begin : g_fast
         assign last_cyc = 1'b1;
      end else begin : g_cnt
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              cnt <= '0;
            else if (!run || cnt == CNT_W'(HALF_CYC - 1)) cnt <= '0;
            else                                     cnt <= cnt + 1'b1;
         end
         assign last_cyc = (cnt == CNT_W'(HALF_CYC - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                half <= HALF_LEAD;
      else if (!run)             half <= HALF_LEAD;
      else if (last_cyc)         half <= (half == HALF_LEAD) ? HALF_TRAIL : HALF_LEAD;
   end

   assign mid_stb = run && last_cyc && (half == HALF_LEAD);
   assign end_stb = run && last_cyc && (half == HALF_TRAIL);

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mid_stb, end_stb}));
   // R5
   half_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mid_stb |=> (half == HALF_TRAIL));
endmodule

// File: rtl/sb_tx_shift.sv
module sb_tx_shift #(
   parameter int unsigned MAX_LEN = 16,
   parameter int unsigned LEN_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic               shift,
   input  logic [MAX_LEN-1:0] word,
   input  logic [LEN_W-1:0]   len_m1,
   input  logic               lead_en,
   input  logic               lead_val,
   output logic               out_bit
);
   localparam int unsigned SR_W = MAX_LEN + 1;

   logic [SR_W-1:0]    sr;
   logic [MAX_LEN-1:0] aligned;
   logic [LEN_W-1:0]   pad;

   assign pad     = LEN_W'(MAX_LEN - 1) - len_m1;
   assign aligned = word << pad;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sr <= '0;
      else if (load)  sr <= lead_en ? {lead_val, aligned} : {aligned, 1'b0};
      else if (shift) sr <= {sr[SR_W-2:0], 1'b0};
   end

   assign out_bit = sr[SR_W-1];
endmodule

// File: rtl/sb_rx_collect.sv
module sb_rx_collect #(
   parameter int unsigned MAX_LEN = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               take,
   input  logic               din,
   output logic [MAX_LEN-1:0] word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     word <= '0;
      else if (clear) word <= '0;
      else if (take)  word <= {word[MAX_LEN-2:0], din};
   end
endmodule

// File: rtl/spi_sb_framer.sv
module spi_sb_framer
   import spi_sb_pkg::*;
#(
   parameter int unsigned MAX_LEN  = 16,
   parameter int unsigned HALF_CYC = 2,
   localparam int unsigned LEN_W   = $clog2(MAX_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_stb,
   input  logic [MAX_LEN-1:0] tx_word,
   input  logic [LEN_W-1:0]   word_len,
   input  logic               lead_en,
   input  logic               lead_val,
   input  logic               cpol,
   input  logic               cpha,
   input  logic               miso,
   output logic               sclk,
   output logic               mosi,
   output logic               busy,
   output logic [MAX_LEN-1:0] rx_word,
   output logic               rx_valid
);
   localparam int unsigned NB_W = $clog2(MAX_LEN + 2);

   generate
      if (MAX_LEN < 2) begin : g_len_bad
         $error("MAX_LEN must be at least 2");
      end
   endgenerate

   logic            accept, mid_stb, end_stb, last_bit, lead_cur;
   logic            cpol_q, cpha_q, tx_bit;
   logic [NB_W-1:0] bits_left;
   logic [MAX_LEN-1:0] rx_sh;
   half_e           half;

   assign accept   = wr_stb && !busy;
   assign last_bit = (bits_left == NB_W'(1));

   sb_tick_gen #(.HALF_CYC(HALF_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy),
      .mid_stb(mid_stb), .end_stb(end_stb), .half(half)
   );

   sb_tx_shift #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .load(accept), .shift(end_stb),
      .word(tx_word), .len_m1(word_len), .lead_en(lead_en),
      .lead_val(lead_val), .out_bit(tx_bit)
   );

   sb_rx_collect #(.MAX_LEN(MAX_LEN)) u_rx (
      .clk(clk), .rst_n(rst_n), .clear(accept),
      .take(mid_stb && !lead_cur), .din(miso), .word(rx_sh)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         lead_cur  <= 1'b0;
         bits_left <= '0;
         cpol_q    <= 1'b0;
         cpha_q    <= 1'b0;
      end else if (accept) begin
         busy      <= 1'b1;
         lead_cur  <= lead_en;
         bits_left <= NB_W'(word_len) + NB_W'(1) + NB_W'(lead_en);
         cpol_q    <= cpol;
         cpha_q    <= cpha;
      end else if (end_stb) begin
         lead_cur  <= 1'b0;
         bits_left <= bits_left - 1'b1;
         if (last_bit) busy <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_word  <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= end_stb && last_bit;
         if (end_stb && last_bit) rx_word <= rx_sh;
      end
   end

   assign sclk = busy ? (cpol_q ^ (cpha_q ? (half == HALF_LEAD) : (half == HALF_TRAIL))) : cpol;
   assign mosi = busy && tx_bit;

   // R2
   bits_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (bits_left != '0));
   // R8
   rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> (!busy && $past(busy)));
   // R6
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(cpol_q) && $stable(cpha_q)));
   // R3
   lead_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !$past(lead_cur)) |-> !lead_cur);
   // R9
   start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !busy) |=> busy);
endmodule

// File: tb/spi_sb_framer_test.sv
module spi_sb_framer_test;
   localparam int unsigned ML = 8;
   localparam int unsigned HC = 2;
   localparam int unsigned LW = $clog2(ML);

   logic          clk = 1'b0, rst_n = 1'b0, wr_stb = 1'b0;
   logic [ML-1:0] tx_word = '0;
   logic [LW-1:0] word_len = '0;
   logic          lead_en = 1'b0, lead_val = 1'b0, cpol = 1'b0, cpha = 1'b0;
   logic          inv = 1'b0;
   logic          sclk, mosi, busy, rx_valid, miso;
   logic [ML-1:0] rx_word;

   int total = 0, bad = 0, cyc = 0;
   logic ecpol = 1'b0, ecpha = 1'b0, prev_sclk = 1'b0;
   logic cap [0:4095];
   int   cap_n = 0, rx_seen = 0;
   logic [ML-1:0] rx_last = '0;

   always #2 clk = ~clk;
   assign miso = mosi ^ inv;

   spi_sb_framer #(.MAX_LEN(ML), .HALF_CYC(HC)) uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .tx_word(tx_word),
      .word_len(word_len), .lead_en(lead_en), .lead_val(lead_val),
      .cpol(cpol), .cpha(cpha), .miso(miso), .sclk(sclk), .mosi(mosi),
      .busy(busy), .rx_word(rx_word), .rx_valid(rx_valid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (busy && prev_sclk != sclk) begin
         if ((ecpha == 1'b0 && prev_sclk == ecpol) || (ecpha == 1'b1 && sclk == ecpol)) begin
            if (cap_n < 4096) cap[cap_n] = mosi;
            cap_n++;
         end
      end
      prev_sclk = sclk;
      if (rx_valid) begin
         rx_seen++;
         rx_last = rx_word;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic frame(input logic [ML-1:0] w, input int len, input logic sb,
                        input logic pol, input logic cp, input logic ch,
                        input logic iv, input logic disturb);
      int base, rbase, n, guard;
      logic [ML-1:0] mask, exp_rx;
      logic e;
      @(negedge clk);
      cpol = cp; cpha = ch; lead_en = sb; lead_val = pol; inv = iv;
      tx_word = w; word_len = LW'(len - 1);
      ecpol = cp; ecpha = ch;
      @(negedge clk);
      chk("R5 idle sclk", {31'd0, sclk}, {31'd0, cp});
      base = cap_n; rbase = rx_seen;
      wr_stb = 1'b1;
      @(negedge clk);
      wr_stb = 1'b0;
      // R9: busy one cycle after the write
      chk("R9 busy rise", {31'd0, busy}, 32'd1);
      if (disturb) begin
         // R6 and R7: move settings and write again mid-frame
         lead_val = ~pol; lead_en = ~sb; tx_word = ~w;
         word_len = LW'(ML - 1 - (len - 1)); cpha = ~ch;
         wr_stb = 1'b1;
         @(negedge clk);
         wr_stb = 1'b0;
      end
      guard = 0;
      while (busy && guard < 1000) begin @(negedge clk); guard++; end
      @(negedge clk);
      n = cap_n - base;
      // R2
      chk("R2 frame bits", n, len + (sb ? 1 : 0));
      for (int i = 0; i < n && i < len + 1; i++) begin
         if (sb && i == 0) e = pol;
         else e = w[len - 1 - (i - (sb ? 1 : 0))];
         // R3 lead bit, R4 word bits
         chk(sb && i == 0 ? "R3 lead bit" : "R4 word bit", {31'd0, cap[base + i]}, {31'd0, e});
      end
      mask = ML'((1 << len) - 1);
      exp_rx = (w ^ (iv ? {ML{1'b1}} : '0)) & mask;
      // R8
      chk("R8 rx pulses", rx_seen - rbase, 1);
      chk("R8 rx word", {24'd0, rx_last}, {24'd0, exp_rx});
      // R7: no second frame after the ignored write
      chk("R7 stays idle", {31'd0, busy}, 32'd0);
      chk("R5 idle after", {31'd0, sclk}, {31'd0, cp});
   endtask

   initial begin
      int k;
      #1;
      // R1
      chk("R1 busy", {31'd0, busy}, 32'd0);
      chk("R1 mosi", {31'd0, mosi}, 32'd0);
      chk("R1 sclk", {31'd0, sclk}, 32'd0);
      chk("R1 rx_valid", {31'd0, rx_valid}, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      k = 0;
      for (int m = 0; m < 4; m++)
         for (int s = 0; s < 2; s++)
            for (int p = 0; p < 2; p++)
               for (int l = 1; l <= ML; l++) begin
                  logic [ML-1:0] w;
                  w = ML'((l * 37 + m * 11 + p * 90 + s * 5) ^ 8'hA5);
                  frame(w, l, s[0], p[0], m[1], m[0], (k % 2) == 1, (k % 3) == 2);
                  k++;
               end
      frame(8'h80, ML, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      frame(8'h01, 1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule